// File: doc/BRIEF.md
# Linked-Descriptor Fetch Sequencer

This block walks a chain of transfer descriptors that sit in memory. Software gives it the address of the first descriptor, sets the descriptor-mode enable and pulses a submit strobe. The block then reads each 48-byte descriptor over its own read-only memory port as one burst of six 64-bit beats. It unpacks the fields and hands one transfer command to a downstream copy engine over a valid/ready channel. Once the copy engine reports that the transfer is done, the block either fetches the descriptor named by the next-pointer field or goes back to idle.

Two flag bits in each descriptor steer the chain. Bit 0 ends the chain after the current descriptor. Bit 1 asks for a one-cycle interrupt pulse when that segment's transfer is done. The id of the most recently completed descriptor is held on a status output. A read beat with a non-OKAY response aborts the chain and sets a sticky error flag. While descriptor mode is on, the legacy cyclic-repeat request is masked off.

Top module: `sgf_fetch_engine`

## Requirements
- R1: A submit pulse is accepted only while the block is idle and descriptor mode is enabled. An accepted submit raises `ar_valid` with `ar_addr` equal to the programmed start address and `ar_len` equal to 5, meaning six beats. Both stay stable until `ar_ready`. A submit with the mode off, or while busy, changes nothing.
- R2: The beats are taken in this layout. Beat 0 carries flags in bits [31:0] and id in bits [63:32]. Beat 1 is the destination address, beat 2 the source address and beat 3 the next-descriptor address. Beat 4 carries the y length in [31:0] and the x length in [63:32]. Beat 5 carries the source stride in [31:0] and the destination stride in [63:32]. The command outputs carry these values unchanged, and the x length stays in its stored bytes-minus-one form.
- R3: `cmd_valid` rises the cycle after the sixth beat is accepted. It stays high, with every command field stable, until `cmd_ready` is seen.
- R4: No descriptor read is issued between the acceptance of a command and the cycle in which `xfer_done` is sampled high.
- R5: On `xfer_done`, a descriptor with flag bit 0 set returns the block to idle. With the bit clear, the next cycle shows `ar_valid` at the next-descriptor address.
- R6: On `xfer_done`, `done_id` takes that descriptor's id in the next cycle and holds it until the next completion. `irq` is high for exactly that one cycle when flag bit 1 was set, and is low otherwise.
- R7: A beat with `r_resp` other than 0 (OKAY) still lets the burst finish. The block then issues no command, returns to idle and sets `desc_err`. The flag stays set until the next accepted submit clears it.
- R8: `cyclic_en` equals `cfg_cyclic` while `cfg_desc_mode` is low and is 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_desc_addr | input | ADDR_W | Address of the first descriptor |
| cfg_desc_mode | input | 1 | Descriptor-mode enable |
| cfg_submit | input | 1 | Start strobe |
| cfg_cyclic | input | 1 | Legacy cyclic-repeat request |
| cyclic_en | output | 1 | Cyclic request after masking by descriptor mode |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | ADDR_W | Descriptor address |
| ar_len | output | 8 | Burst length minus one (5) |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready |
| r_data | input | 64 | Read beat |
| r_resp | input | 2 | Read response, 0 = OKAY |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Transfer command accepted |
| cmd_dst_addr | output | ADDR_W | Destination address |
| cmd_src_addr | output | ADDR_W | Source address |
| cmd_x_len | output | 32 | Bytes to move minus one |
| cmd_y_len | output | 32 | 2D row count field |
| cmd_src_stride | output | 32 | 2D source stride |
| cmd_dst_stride | output | 32 | 2D destination stride |
| cmd_id | output | 32 | Descriptor id |
| xfer_done | input | 1 | Copy engine finished the current command |
| irq | output | 1 | One-cycle segment interrupt |
| done_id | output | 32 | Id of the last completed descriptor |
| busy | output | 1 | Chain in progress |
| desc_err | output | 1 | Sticky fetch error |

## Verification
The completion of one segment and the launch of the next fetch fall on the same clock edge. The interrupt pulse and the `done_id` update appear in the very cycle that `ar_valid` rises for the following descriptor. The bench provokes this by running chains of one to four descriptors under every interrupt-flag pattern. In the cycle after each `xfer_done` it checks `irq`, `done_id` and the new read address together. A second overlap is a submit strobe while a transfer is outstanding. The bench pulses submit with a foreign address in that window and confirms the next read still goes to the chained pointer.

// File: rtl/sgf_pkg.sv
// Shared types for the linked-descriptor fetch sequencer.
// Assumes a 64-bit descriptor bus and a fixed 48-byte descriptor.
package sgf_pkg;
    localparam int BEAT_W     = 64;
    localparam int FIELD_W    = 32;
    localparam int DESC_BEATS = 6;
    localparam int IDX_W      = $clog2(DESC_BEATS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_BEATS,
        ST_ISSUE,
        ST_WAIT
    } sgf_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] flags;
        logic [FIELD_W-1:0] id;
        logic [BEAT_W-1:0]  dst;
        logic [BEAT_W-1:0]  src;
        logic [BEAT_W-1:0]  nxt;
        logic [FIELD_W-1:0] ylen;
        logic [FIELD_W-1:0] xlen;
        logic [FIELD_W-1:0] sstride;
        logic [FIELD_W-1:0] dstride;
    } sgf_desc_t;
endpackage

// File: rtl/sgf_desc_store.sv
// Holds the beats of one descriptor and presents them as named fields.
// Assumes beats arrive with an index 0..DESC_BEATS-1 and that two 32-bit
// fields share a beat with the earlier field in the low half.
module sgf_desc_store
    import sgf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_we,
    input  logic [IDX_W-1:0] beat_idx,
    input  logic [BEAT_W-1:0] beat_data,
    output sgf_desc_t        desc
);
    logic [BEAT_W-1:0] beat_q [DESC_BEATS];

    for (genvar g = 0; g < DESC_BEATS; g++) begin : g_beat
        // Capture beat g when it is the one arriving.
        always_ff @(posedge clk) begin
            if (!rst_n)
                beat_q[g] <= '0;
            else if (beat_we && (beat_idx == IDX_W'(g)))
                beat_q[g] <= beat_data;
        end
    end

    // Map the stored beats onto descriptor fields.
    always_comb begin
        desc.flags   = beat_q[0][FIELD_W-1:0];
        desc.id      = beat_q[0][BEAT_W-1:FIELD_W];
        desc.dst     = beat_q[1];
        desc.src     = beat_q[2];
        desc.nxt     = beat_q[3];
        desc.ylen    = beat_q[4][FIELD_W-1:0];
        desc.xlen    = beat_q[4][BEAT_W-1:FIELD_W];
        desc.sstride = beat_q[5][FIELD_W-1:0];
        desc.dstride = beat_q[5][BEAT_W-1:FIELD_W];
    end
endmodule

// File: rtl/sgf_seq.sv
// Chain sequencer: address phase, beat collection, command issue, and
// the wait for the copy engine. Assumes the memory always returns exactly
// DESC_BEATS beats per accepted address.
module sgf_seq
    import sgf_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              submit_ok,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              chain_end,
    input  logic              ar_ready,
    input  logic              r_valid,
    input  logic [1:0]        r_resp,
    input  logic              cmd_ready,
    input  logic              xfer_done,
    output sgf_state_e        state,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              beat_we,
    output logic [IDX_W-1:0]  beat_idx,
    output logic              complete,
    output logic              err_flag
);
    sgf_state_e       state_nx;
    logic [IDX_W-1:0] beat_cnt;
    logic             bad_seen;
    logic             last_beat;
    logic             resp_bad;

    assign beat_we   = (state == ST_BEATS) && r_valid;
    assign beat_idx  = beat_cnt;
    assign last_beat = beat_we && (beat_cnt == IDX_W'(DESC_BEATS - 1));
    assign resp_bad  = (r_resp != 2'b00);
    assign complete  = (state == ST_WAIT) && xfer_done;

    // Next-state selection for the chain walk.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (submit_ok) state_nx = ST_ADDR;
            ST_ADDR:  if (ar_ready) state_nx = ST_BEATS;
            ST_BEATS: if (last_beat) state_nx = (bad_seen || resp_bad) ? ST_IDLE : ST_ISSUE;
            ST_ISSUE: if (cmd_ready) state_nx = ST_WAIT;
            ST_WAIT:  if (xfer_done) state_nx = chain_end ? ST_IDLE : ST_ADDR;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Descriptor address: start address on submit, chained pointer on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (state == ST_IDLE && submit_ok)
            cur_addr <= start_addr;
        else if (complete && !chain_end)
            cur_addr <= next_addr;
    end

    // Beat index within the burst.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_ADDR) beat_cnt <= '0;
        else if (beat_we)               beat_cnt <= beat_cnt + 1'b1;
    end

    // Remembers a bad response seen earlier in the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_ADDR) bad_seen <= 1'b0;
        else if (beat_we && resp_bad)   bad_seen <= 1'b1;
    end

    // Sticky error: set by a failed burst, cleared by an accepted submit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (state == ST_IDLE && submit_ok)
            err_flag <= 1'b0;
        else if (last_beat && (bad_seen || resp_bad))
            err_flag <= 1'b1;
    end
endmodule

// File: rtl/sgf_irq_status.sv
// Turns a segment completion into a one-cycle interrupt and latches the
// completed descriptor id. Assumes completion pulses are one cycle long.
module sgf_irq_status
    import sgf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done_pulse,
    input  logic               want_irq,
    input  logic [FIELD_W-1:0] id_in,
    output logic               irq,
    output logic [FIELD_W-1:0] done_id
);
    // Interrupt pulse for segments that requested one.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= done_pulse && want_irq;
    end

    // Last completed id, held until the next completion.
    always_ff @(posedge clk) begin
        if (!rst_n)          done_id <= '0;
        else if (done_pulse) done_id <= id_in;
    end
endmodule

// File: rtl/sgf_fetch_engine.sv
// Linked-descriptor fetch sequencer top. Reads six-beat descriptors over a
// dedicated read port, issues one copy command each, and follows the chain.
// Assumes ADDR_W <= 64 and a downstream engine that pulses xfer_done once
// per accepted command.
module sgf_fetch_engine
    import sgf_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cfg_desc_addr,
    input  logic                cfg_desc_mode,
    input  logic                cfg_submit,
    input  logic                cfg_cyclic,
    output logic                cyclic_en,
    output logic                ar_valid,
    input  logic                ar_ready,
    output logic [ADDR_W-1:0]   ar_addr,
    output logic [7:0]          ar_len,
    input  logic                r_valid,
    output logic                r_ready,
    input  logic [63:0]         r_data,
    input  logic [1:0]          r_resp,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic [ADDR_W-1:0]   cmd_dst_addr,
    output logic [ADDR_W-1:0]   cmd_src_addr,
    output logic [31:0]         cmd_x_len,
    output logic [31:0]         cmd_y_len,
    output logic [31:0]         cmd_src_stride,
    output logic [31:0]         cmd_dst_stride,
    output logic [31:0]         cmd_id,
    input  logic                xfer_done,
    output logic                irq,
    output logic [31:0]         done_id,
    output logic                busy,
    output logic                desc_err
);
    sgf_state_e       state;
    sgf_desc_t        desc;
    logic             beat_we;
    logic [IDX_W-1:0] beat_idx;
    logic             complete;
    logic [ADDR_W-1:0] cur_addr;
    logic             unused_desc_bits;

    assign unused_desc_bits = ^{desc.flags[FIELD_W-1:2], desc.nxt, desc.dst, desc.src};

    sgf_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .submit_ok  (cfg_submit && cfg_desc_mode),
        .start_addr (cfg_desc_addr),
        .next_addr  (desc.nxt[ADDR_W-1:0]),
        .chain_end  (desc.flags[0]),
        .ar_ready   (ar_ready),
        .r_valid    (r_valid),
        .r_resp     (r_resp),
        .cmd_ready  (cmd_ready),
        .xfer_done  (xfer_done),
        .state      (state),
        .cur_addr   (cur_addr),
        .beat_we    (beat_we),
        .beat_idx   (beat_idx),
        .complete   (complete),
        .err_flag   (desc_err)
    );

    sgf_desc_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_we   (beat_we),
        .beat_idx  (beat_idx),
        .beat_data (r_data),
        .desc      (desc)
    );

    sgf_irq_status u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_pulse (complete),
        .want_irq   (desc.flags[1]),
        .id_in      (desc.id),
        .irq        (irq),
        .done_id    (done_id)
    );

    assign cyclic_en      = cfg_cyclic && !cfg_desc_mode;
    assign ar_valid       = (state == ST_ADDR);
    assign ar_addr        = cur_addr;
    assign ar_len         = 8'(DESC_BEATS - 1);
    assign r_ready        = (state == ST_BEATS);
    assign cmd_valid      = (state == ST_ISSUE);
    assign busy           = (state != ST_IDLE);
    assign cmd_dst_addr   = desc.dst[ADDR_W-1:0];
    assign cmd_src_addr   = desc.src[ADDR_W-1:0];
    assign cmd_x_len      = desc.xlen;
    assign cmd_y_len      = desc.ylen;
    assign cmd_src_stride = desc.sstride;
    assign cmd_dst_stride = desc.dstride;
    assign cmd_id         = desc.id;
endmodule

// File: rtl/sgf_fetch_checks.sv
// Protocol and sequencing properties for sgf_fetch_engine, bound to it below.
module sgf_fetch_checks #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_submit,
    input logic              cfg_desc_mode,
    input logic              ar_valid,
    input logic              ar_ready,
    input logic [ADDR_W-1:0] ar_addr,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_src_addr,
    input logic [31:0]       cmd_id,
    input logic              xfer_done,
    input logic              irq,
    input logic              busy,
    input logic              desc_err
);
    // R1: address request held with a stable address until taken.
    p_ar_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr));

    // R3: command held with stable fields until taken.
    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src_addr) && $stable(cmd_id));

    // R4: a fetch starts only after a submit or a completion.
    p_fetch_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ar_valid) |-> $past(xfer_done) || $past(cfg_submit && cfg_desc_mode));

    // R6: the interrupt lasts one cycle.
    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6: the interrupt follows a completion.
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(xfer_done));

    // R7: the error flag rises together with the return to idle.
    p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_err) |-> !busy && !cmd_valid);
endmodule

bind sgf_fetch_engine sgf_fetch_checks #(.ADDR_W(ADDR_W)) u_checks (.*);

// File: tb/tb_sgf_fetch_engine.sv
module tb_sgf_fetch_engine;
    localparam int ADDR_W = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_desc_addr = '0;
    logic cfg_desc_mode = 1'b0, cfg_submit = 1'b0, cfg_cyclic = 1'b0;
    logic cyclic_en, ar_valid, r_ready, cmd_valid, irq, busy, desc_err;
    logic ar_ready = 1'b0, r_valid = 1'b0, cmd_ready = 1'b0, xfer_done = 1'b0;
    logic [ADDR_W-1:0] ar_addr, cmd_dst_addr, cmd_src_addr;
    logic [7:0] ar_len;
    logic [63:0] r_data = '0;
    logic [1:0] r_resp = '0;
    logic [31:0] cmd_x_len, cmd_y_len, cmd_src_stride, cmd_dst_stride, cmd_id, done_id;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sgf_fetch_engine #(.ADDR_W(ADDR_W)) dut (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] d_addr(int tag, int k);
        return 64'h0000_0010_0000_0000 + 64'(tag) * 64'h1000 + 64'(k) * 64'h40;
    endfunction
    function automatic logic [31:0] f_flags(int k, int len, logic [3:0] mask);
        return {30'b0, mask[k], (k == len - 1)};
    endfunction
    function automatic logic [31:0] f_id(int tag, int k);
        return 32'hA000_0000 | (32'(tag) << 8) | 32'(k);
    endfunction
    function automatic logic [63:0] f_dst(int tag, int k);
        return 64'h8000_0000_0000_0000 + 64'(tag) * 64'h1_0000 + 64'(k) * 64'h100;
    endfunction
    function automatic logic [63:0] f_src(int tag, int k);
        return 64'h4000_0000_0000_0003 + 64'(tag) * 64'h1_0000 + 64'(k) * 64'h200;
    endfunction
    function automatic logic [31:0] f_y(int k);          return 32'(k); endfunction
    function automatic logic [31:0] f_x(int tag, int k); return 32'h3F + 32'(k * 7) + 32'(tag); endfunction
    function automatic logic [31:0] f_ss(int tag, int k); return 32'(tag * 2 + k); endfunction
    function automatic logic [31:0] f_ds(int k);         return 32'hFFFF_0000 | 32'(k); endfunction

    function automatic logic [63:0] beat(int tag, int k, int len, logic [3:0] mask, int b);
        case (b)
            0: return {f_id(tag, k), f_flags(k, len, mask)};
            1: return f_dst(tag, k);
            2: return f_src(tag, k);
            3: return d_addr(tag, k + 1);
            4: return {f_x(tag, k), f_y(k)};
            default: return {f_ds(k), f_ss(tag, k)};
        endcase
    endfunction

    // One chain of len descriptors; err_beat < 6 corrupts that beat of descriptor 0.
    task automatic run_chain(int tag, int len, logic [3:0] mask,
                             int ar_gap, int r_gap, int cmd_gap, int err_beat);
        cfg_desc_addr = d_addr(tag, 0);
        cfg_desc_mode = 1'b1;
        cfg_submit = 1'b1;
        tick();
        cfg_submit = 1'b0;
        chk("R1 busy after submit", 64'(busy), 64'd1);
        chk("R7 error cleared by submit", 64'(desc_err), 64'd0);
        for (int k = 0; k < len; k++) begin
            while (!ar_valid) tick();
            chk(k == 0 ? "R1 start address" : "R5 chained address", ar_addr, d_addr(tag, k));
            chk("R1 burst length", 64'(ar_len), 64'd5);
            repeat (ar_gap) tick();
            chk("R1 address held", {63'b0, ar_valid} ^ 64'(ar_addr != d_addr(tag, k)), 64'd1);
            ar_ready = 1'b1;
            tick();
            ar_ready = 1'b0;
            for (int b = 0; b < 6; b++) begin
                repeat (r_gap) tick();
                r_valid = 1'b1;
                r_data = beat(tag, k, len, mask, b);
                r_resp = (k == 0 && b == err_beat) ? 2'b10 : 2'b00;
                chk("R2 beat accepted", 64'(r_ready), 64'd1);
                tick();
                r_valid = 1'b0;
                r_resp = 2'b00;
            end
            if (k == 0 && err_beat < 6) begin
                chk("R7 idle after bad beat", 64'(busy), 64'd0);
                chk("R7 error flag", 64'(desc_err), 64'd1);
                chk("R7 no command", 64'(cmd_valid), 64'd0);
                repeat (3) tick();
                chk("R7 no further fetch", 64'(ar_valid), 64'd0);
                chk("R7 error sticky", 64'(desc_err), 64'd1);
                return;
            end
            chk("R3 command raised", 64'(cmd_valid), 64'd1);
            repeat (cmd_gap) tick();
            chk("R3 command held", 64'(cmd_valid), 64'd1);
            chk("R2 dst", cmd_dst_addr, f_dst(tag, k));
            chk("R2 src", cmd_src_addr, f_src(tag, k));
            chk("R2 xlen", 64'(cmd_x_len), 64'(f_x(tag, k)));
            chk("R2 ylen", 64'(cmd_y_len), 64'(f_y(k)));
            chk("R2 sstride", 64'(cmd_src_stride), 64'(f_ss(tag, k)));
            chk("R2 dstride", 64'(cmd_dst_stride), 64'(f_ds(k)));
            chk("R2 id", 64'(cmd_id), 64'(f_id(tag, k)));
            cmd_ready = 1'b1;
            tick();
            cmd_ready = 1'b0;
            chk("R3 command dropped", 64'(cmd_valid), 64'd0);
            cfg_desc_addr = 64'hDEAD_0000_0000_0040;
            cfg_submit = 1'b1;
            tick();
            cfg_submit = 1'b0;
            repeat (2) tick();
            chk("R4 no fetch before done", 64'(ar_valid), 64'd0);
            chk("R6 no early irq", 64'(irq), 64'd0);
            xfer_done = 1'b1;
            tick();
            xfer_done = 1'b0;
            chk("R6 irq on completion", 64'(irq), 64'(mask[k]));
            chk("R6 done id", 64'(done_id), 64'(f_id(tag, k)));
            if (k == len - 1) chk("R5 chain end idle", 64'(busy), 64'd0);
            else              chk("R5 next fetch", 64'(ar_valid), 64'd1);
            tick();
            chk("R6 irq one cycle", 64'(irq), 64'd0);
            chk("R6 done id held", 64'(done_id), 64'(f_id(tag, k)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int tag;
        tag = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset busy", 64'(busy), 64'd0);
        chk("R1 reset ar_valid", 64'(ar_valid), 64'd0);
        chk("R3 reset cmd_valid", 64'(cmd_valid), 64'd0);
        chk("R6 reset irq", 64'(irq), 64'd0);
        chk("R7 reset error", 64'(desc_err), 64'd0);

        // R1: submit ignored with descriptor mode off.
        cfg_desc_addr = d_addr(9, 0);
        cfg_desc_mode = 1'b0;
        cfg_submit = 1'b1;
        tick();
        cfg_submit = 1'b0;
        chk("R1 mode off ignored busy", 64'(busy), 64'd0);
        chk("R1 mode off ignored fetch", 64'(ar_valid), 64'd0);

        // R8: cyclic masking over all combinations.
        for (int m = 0; m < 4; m++) begin
            cfg_desc_mode = m[0];
            cfg_cyclic = m[1];
            tick();
            chk("R8 cyclic mask", 64'(cyclic_en), 64'(m[1] && !m[0]));
        end
        cfg_cyclic = 1'b0;

        // Every chain length 1..4 with every interrupt-flag pattern.
        for (int len = 1; len <= 4; len++) begin
            for (int mask = 0; mask < (1 << len); mask++) begin
                run_chain(tag, len, 4'(mask), (len + mask) % 3, mask % 2, (mask + 1) % 3, 7);
                tag++;
            end
        end

        // R7: a bad response on each beat position, then a clean chain.
        for (int eb = 0; eb < 6; eb++) begin
            run_chain(tag, 2, 4'b0011, eb % 2, eb % 3, 0, eb);
            tag++;
            run_chain(tag, 2, 4'b0010, 0, 0, 1, 7);
            tag++;
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule